// File: doc/BRIEF.md
# Invalidate-Based Snooping Cache Controller

This block is a small direct-mapped cache with single-word lines that stays coherent with peer caches by watching a shared broadcast bus. Each line holds a tag, one data word and a coherence state: invalid, clean (a read-only copy that other caches may also hold) or dirty (the only valid copy, held by this cache as owner). A processor read that finds a valid matching line completes in the same cycle. A write to a line this cache already owns as dirty also completes at once, with no bus traffic. Any other request asks for the bus, waits for a grant from an external single-cycle arbiter, and then broadcasts its address, fetches the word from memory and installs the line.

The tag lookup for snooping uses its own read port, separate from the processor lookup. Remote writes that hit a valid copy invalidate it. Remote reads that hit a dirty copy push the value back to memory and demote the line to clean. A dirty line that is about to be replaced is written back in the same cycle as the fill that replaces it.

Top module: `coh_cache`

## Requirements
- R1: After reset every line is invalid: with no request all outputs are low, and the first processor read to any address raises busReq.
- R2: A read whose line is valid with a matching tag asserts cpuDone in the same cycle with the stored word on cpuRdata, and busReq stays low.
- R3: A read miss holds busReq high with cpuDone low until busGrant. In the grant cycle busCmd is 1 (read), memRd is high, busAddr equals cpuAddr, cpuDone is high and cpuRdata equals memRdData. The line then becomes clean.
- R4: A write to a line that is invalid, clean or tagged for another address requests the bus. In the grant cycle busCmd is 2 (write), memRd is high and busAddr equals cpuAddr. The line then holds cpuWdata in the dirty state.
- R5: A write whose line is dirty with a matching tag completes in the same cycle, with busReq low and busCmd 0, and it updates the stored word.
- R6: A snooped write (snpIsWrite=1) whose address matches a valid line invalidates it. If that line was dirty, the same cycle carries a write-back of its address and word. A snoop whose tag does not match changes nothing.
- R7: A snooped read (snpIsWrite=0) that matches a dirty line writes the word back in the same cycle and leaves the line clean. A later local write to that line then needs the bus again. A snooped read of a clean line does nothing.
- R8: When a granted request replaces a dirty line that holds another tag, wbValid is high in the grant cycle with the old line's address (tag above index) and its word.
- R9: When a snoop targets the same line index as a pending processor request, the snoop takes priority: cpuDone and busReq stay low for that cycle. A snoop to a different index does not hold up a hit.
- R10: cpuDone is only ever high together with cpuReq, and busCmd is non-zero only in a cycle where busGrant is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor request, held until cpuDone |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpuWdata | input | DATA_W | Write data |
| cpuDone | output | 1 | Request completes this cycle |
| cpuRdata | output | DATA_W | Read data, valid with cpuDone on a read |
| busReq | output | 1 | Bus needed for the pending request |
| busGrant | input | 1 | Arbiter grant for this cycle |
| busCmd | output | 2 | Broadcast: 0 none, 1 read, 2 write |
| busAddr | output | ADDR_W | Broadcast and fetch address |
| memRd | output | 1 | Fetch strobe for the word at busAddr |
| memRdData | input | DATA_W | Fetched word, same cycle as memRd |
| snpValid | input | 1 | Snooped remote transaction present |
| snpIsWrite | input | 1 | 1 = remote write, 0 = remote read |
| snpAddr | input | ADDR_W | Snooped address |
| wbValid | output | 1 | Write-back to memory this cycle |
| wbAddr | output | ADDR_W | Write-back address |
| wbData | output | DATA_W | Write-back word |

## Verification
The assertions assume that busGrant is never high while snpValid is high. Both write-back sources share one port, and the arbiter gives the bus to a single cache, so this cache's grant and a peer's snooped transaction cannot fall in the same cycle. They also assume that cpuReq, cpuWe, cpuAddr and cpuWdata stay steady until cpuDone, and that the grant comes only in answer to busReq. The stimulus follows these rules. It raises busGrant only from the model's own expectation of busReq, it keeps snoops and grants in separate cycles, and it holds every request unchanged until the model predicts completion.

// File: rtl/coh_cache_pkg.sv
`timescale 1ns/1ps
package coh_cache_pkg;

  typedef enum logic [1:0] {
    LS_INV   = 2'd0,
    LS_CLEAN = 2'd1,
    LS_DIRTY = 2'd2
  } lineState_e;

  typedef enum logic [1:0] {
    BC_NONE  = 2'd0,
    BC_READ  = 2'd1,
    BC_WRITE = 2'd2
  } busCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       fillEn;      // write tag, word and state at processor index
    logic       fillFromCpu; // word source: processor data, else memory
    lineState_e fillState;
    logic       snpEn;       // write state at snoop index
    lineState_e snpState;
    logic       wbEn;        // write-back this cycle
    logic       wbFromSnp;   // write-back source: snoop line, else victim
  } ctrlStrobe_t;

endpackage

// File: rtl/coh_cache_dp.sv
`timescale 1ns/1ps
module coh_cache_dp
  import coh_cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  ctrlStrobe_t       strobe,
  output lineState_e        cpuState,
  output logic              cpuTagEq,
  output lineState_e        snpState,
  output logic              snpTagEq,
  output logic              idxClash,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  lineState_e        stArr  [LINES];
  logic [TAG_W-1:0]  tagArr [LINES];
  logic [DATA_W-1:0] datArr [LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  // processor lookup port
  assign cpuState = stArr[cpuIdx];
  assign cpuTagEq = (tagArr[cpuIdx] == cpuTag);
  // independent snoop lookup port
  assign snpState = stArr[snpIdx];
  assign snpTagEq = (tagArr[snpIdx] == snpTag);
  assign idxClash = (cpuIdx == snpIdx);

  // per-line coherence state; snoop and fill never share an index
  for (genvar g = 0; g < LINES; g++) begin : gLine
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        stArr[g] <= LS_INV;
      else if (strobe.fillEn && cpuIdx == IDX_W'(g))
        stArr[g] <= strobe.fillState;
      else if (strobe.snpEn && snpIdx == IDX_W'(g))
        stArr[g] <= strobe.snpState;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillEn) begin
      tagArr[cpuIdx] <= cpuTag;
      datArr[cpuIdx] <= strobe.fillFromCpu ? cpuWdata : memRdData;
    end
  end

  always_comb begin
    if (strobe.fillEn && !strobe.fillFromCpu)
      cpuRdata = memRdData;
    else
      cpuRdata = datArr[cpuIdx];
  end

  always_comb begin
    wbAddr = '0;
    wbData = '0;
    if (strobe.wbEn) begin
      if (strobe.wbFromSnp) begin
        wbAddr = {tagArr[snpIdx], snpIdx};
        wbData = datArr[snpIdx];
      end else begin
        wbAddr = {tagArr[cpuIdx], cpuIdx};
        wbData = datArr[cpuIdx];
      end
    end
  end

  // R7: a demoting snoop leaves the line clean on the next cycle
  p_snoop_demote_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.snpEn && strobe.snpState == LS_CLEAN) |=> (stArr[$past(snpIdx)] == LS_CLEAN))
    else $error("R7 snoop demotion lost");

  // R4: a write fill leaves the line dirty on the next cycle
  p_fill_dirty_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillEn && strobe.fillState == LS_DIRTY) |=> (stArr[$past(cpuIdx)] == LS_DIRTY))
    else $error("R4 dirty fill lost");

  // R8: replacing a dirty line of another tag must write it back
  p_evict_wb_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillEn && cpuState == LS_DIRTY && !cpuTagEq) |-> (strobe.wbEn && !strobe.wbFromSnp))
    else $error("R8 dirty victim dropped");

endmodule

// File: rtl/coh_cache_ctrl.sv
`timescale 1ns/1ps
module coh_cache_ctrl
  import coh_cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic        busGrant,
  input  logic        snpValid,
  input  logic        snpIsWrite,
  input  lineState_e  cpuState,
  input  logic        cpuTagEq,
  input  lineState_e  snpState,
  input  logic        snpTagEq,
  input  logic        idxClash,
  output ctrlStrobe_t strobe,
  output logic        cpuDone,
  output logic        busReq,
  output busCmd_e     busCmd,
  output logic        memRd,
  output logic        wbValid
);
  logic snpMatch, snpDirty, cpuGo, cpuHit, localOk, needBus, granted, victimDirty;

  always_comb begin
    snpMatch    = snpValid && (snpState != LS_INV) && snpTagEq;
    snpDirty    = snpMatch && (snpState == LS_DIRTY);
    cpuGo       = cpuReq && !(snpValid && idxClash);
    cpuHit      = (cpuState != LS_INV) && cpuTagEq;
    localOk     = cpuHit && (!cpuWe || cpuState == LS_DIRTY);
    needBus     = cpuGo && !localOk;
    granted     = needBus && busGrant;
    victimDirty = granted && (cpuState == LS_DIRTY) && !cpuTagEq;

    busReq  = needBus;
    cpuDone = (cpuGo && localOk) || granted;
    memRd   = granted;
    busCmd  = granted ? (cpuWe ? BC_WRITE : BC_READ) : BC_NONE;

    strobe.fillEn      = granted || (cpuGo && localOk && cpuWe);
    strobe.fillFromCpu = cpuWe;
    strobe.fillState   = cpuWe ? LS_DIRTY : LS_CLEAN;
    strobe.snpEn       = snpMatch && (snpIsWrite || snpDirty);
    strobe.snpState    = snpIsWrite ? LS_INV : LS_CLEAN;
    strobe.wbEn        = snpDirty || victimDirty;
    strobe.wbFromSnp   = snpDirty;
    wbValid            = strobe.wbEn;
  end

  // R10: no broadcast without a grant
  p_cmd_needs_grant_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busCmd != BC_NONE) |-> busGrant)
    else $error("R10 broadcast without grant");

  // R10: completion only for a live request
  p_done_needs_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> cpuReq)
    else $error("R10 spurious completion");

  // R9: a snoop to the requested line index holds the processor off
  p_snoop_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && idxClash) |-> (!cpuDone && !busReq))
    else $error("R9 snoop priority broken");

  // R6: a remote write on an owned line must push the word out
  p_dirty_snoop_wb_r6: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpIsWrite && snpTagEq && snpState == LS_DIRTY) |-> wbValid)
    else $error("R6 owned word lost on remote write");

endmodule

// File: rtl/coh_cache.sv
`timescale 1ns/1ps
module coh_cache
  import coh_cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  input  logic              busGrant,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic              memRd,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              snpValid,
  input  logic              snpIsWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);
  ctrlStrobe_t strobe;
  lineState_e  cpuState, snpState;
  logic        cpuTagEq, snpTagEq, idxClash;
  busCmd_e     cmdEnum;

  coh_cache_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .snpAddr(snpAddr), .memRdData(memRdData), .strobe(strobe),
    .cpuState(cpuState), .cpuTagEq(cpuTagEq), .snpState(snpState),
    .snpTagEq(snpTagEq), .idxClash(idxClash), .cpuRdata(cpuRdata),
    .wbAddr(wbAddr), .wbData(wbData)
  );

  coh_cache_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .busGrant(busGrant), .snpValid(snpValid), .snpIsWrite(snpIsWrite),
    .cpuState(cpuState), .cpuTagEq(cpuTagEq), .snpState(snpState),
    .snpTagEq(snpTagEq), .idxClash(idxClash), .strobe(strobe),
    .cpuDone(cpuDone), .busReq(busReq), .busCmd(cmdEnum),
    .memRd(memRd), .wbValid(wbValid)
  );

  assign busCmd  = cmdEnum;
  assign busAddr = cpuAddr;

endmodule

// File: tb/sim_coh_cache.sv
`timescale 1ns/1ps
module sim_coh_cache;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, cpuReq, cpuWe, cpuDone, busReq, busGrant, memRd;
  logic snpValid, snpIsWrite, wbValid;
  logic [7:0]  cpuAddr, busAddr, snpAddr, wbAddr;
  logic [15:0] cpuWdata, cpuRdata, memRdData, wbData;
  logic [1:0]  busCmd;

  logic [15:0] mem [256];
  assign memRdData = mem[busAddr];

  coh_cache u0 (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuDone(cpuDone), .cpuRdata(cpuRdata), .busReq(busReq),
    .busGrant(busGrant), .busCmd(busCmd), .busAddr(busAddr), .memRd(memRd),
    .memRdData(memRdData), .snpValid(snpValid), .snpIsWrite(snpIsWrite),
    .snpAddr(snpAddr), .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData)
  );

  int errs = 0, checks = 0;
  // reference model: 0 invalid, 1 clean, 2 dirty
  int mSt [4];
  int mTag [4];
  logic [15:0] mDat [4];
  logic grantOn = 1'b0;
  logic eDone, eReq, eMemRd, eWb;
  logic [1:0] eCmd;
  logic [7:0] eWbAddr;
  logic [15:0] eWbData, eRdata;

  task automatic chk(input string req, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic cycle(input string req);
    int ci, ct, si, st;
    logic conflict, sMatch, hit, localOk, need, grant;
    #1;
    ci = int'(cpuAddr[1:0]); ct = int'(cpuAddr[7:2]);
    si = int'(snpAddr[1:0]); st = int'(snpAddr[7:2]);
    eDone = 0; eReq = 0; eMemRd = 0; eWb = 0; eCmd = 0; eWbAddr = 0; eWbData = 0; eRdata = 0;
    conflict = snpValid && cpuReq && (si == ci);
    sMatch = snpValid && mSt[si] != 0 && mTag[si] == st;
    if (sMatch && mSt[si] == 2) begin
      eWb = 1; eWbAddr = 8'(mTag[si] * 4 + si); eWbData = mDat[si];
    end
    hit = mSt[ci] != 0 && mTag[ci] == ct;
    localOk = hit && (!cpuWe || mSt[ci] == 2);
    need = cpuReq && !conflict && !localOk;
    grant = need && grantOn && !snpValid;
    eReq = need;
    if (cpuReq && !conflict && localOk) begin
      eDone = 1; eRdata = mDat[ci];
    end
    if (grant) begin
      eDone = 1; eMemRd = 1; eCmd = cpuWe ? 2'd2 : 2'd1;
      eRdata = mem[cpuAddr];
      if (mSt[ci] == 2 && mTag[ci] != ct) begin
        eWb = 1; eWbAddr = 8'(mTag[ci] * 4 + ci); eWbData = mDat[ci];
      end
    end
    busGrant = grant;
    #1;
    chk(req, "cpuDone", int'(cpuDone), int'(eDone));
    chk(req, "busReq", int'(busReq), int'(eReq));
    chk(req, "busCmd", int'(busCmd), int'(eCmd));
    chk(req, "memRd", int'(memRd), int'(eMemRd));
    chk(req, "wbValid", int'(wbValid), int'(eWb));
    if (eWb) begin
      chk(req, "wbAddr", int'(wbAddr), int'(eWbAddr));
      chk(req, "wbData", int'(wbData), int'(eWbData));
    end
    if (eCmd != 0) chk(req, "busAddr", int'(busAddr), int'(cpuAddr));
    if (eDone && !cpuWe) chk(req, "cpuRdata", int'(cpuRdata), int'(eRdata));
    @(posedge clk);
    if (eWb) mem[eWbAddr] = eWbData;
    if (sMatch) begin
      if (snpIsWrite) mSt[si] = 0;
      else if (mSt[si] == 2) mSt[si] = 1;
    end
    if (eDone && (grant || cpuWe)) begin
      mTag[ci] = ct;
      mDat[ci] = cpuWe ? cpuWdata : eRdata;
      mSt[ci] = cpuWe ? 2 : 1;
    end
    @(negedge clk);
    busGrant = 0;
  endtask

  task automatic op(input logic we, input logic [7:0] a, input logic [15:0] d,
                    input int wait_n, input string req);
    int waits = 0;
    cpuReq = 1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    do begin
      grantOn = (waits >= wait_n);
      cycle(req);
      waits++;
    end while (!eDone && waits < 40);
    cpuReq = 0; cpuWe = 0; grantOn = 0;
  endtask

  task automatic snoop(input logic w, input logic [7:0] a, input string req);
    snpValid = 1; snpIsWrite = w; snpAddr = a;
    cycle(req);
    snpValid = 0; snpIsWrite = 0;
  endtask

  initial begin
    #1000000;
    errs++; checks++;
    $display("FAIL R10 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 37 + 16'h1000);
    for (int i = 0; i < 4; i++) begin mSt[i] = 0; mTag[i] = 0; mDat[i] = 0; end
    rstN = 0; cpuReq = 0; cpuWe = 0; cpuAddr = 0; cpuWdata = 0;
    busGrant = 0; snpValid = 0; snpIsWrite = 0; snpAddr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    cycle("R1");                               // idle after reset
    op(0, 8'h10, 0, 2, "R3");                  // miss, two cycles before grant (R1, R10)
    op(0, 8'h10, 0, 0, "R2");                  // hit
    op(1, 8'h10, 16'hBEEF, 1, "R4");           // clean -> dirty via bus
    op(1, 8'h10, 16'hCAFE, 0, "R5");           // owned write, no bus
    op(0, 8'h10, 0, 0, "R5");                  // reads back new word
    snoop(0, 8'h10, "R7");                     // remote read: write back, demote
    op(1, 8'h10, 16'h1234, 0, "R7");           // needs bus again
    snoop(1, 8'h14, "R6");                     // other tag, same index: ignored
    op(0, 8'h10, 0, 0, "R6");                  // still a hit
    snoop(1, 8'h10, "R6");                     // remote write on dirty: wb + invalidate
    op(0, 8'h10, 0, 0, "R6");                  // misses now
    op(0, 8'h21, 0, 0, "R3");
    snoop(0, 8'h21, "R7");                     // remote read on clean: nothing
    snoop(1, 8'h21, "R6");                     // remote write on clean: no wb
    op(0, 8'h21, 0, 1, "R6");
    op(1, 8'h22, 16'h5555, 0, "R4");
    op(1, 8'h32, 16'h6666, 0, "R8");           // evicts dirty 0x22
    op(0, 8'h42, 0, 0, "R8");                  // evicts dirty 0x32
    cpuReq = 1; cpuWe = 0; cpuAddr = 8'h21;    // same-index snoop holds off a hit
    snpValid = 1; snpIsWrite = 0; snpAddr = 8'h01;
    cycle("R9");
    snpAddr = 8'h42;                           // other index: hit proceeds
    cycle("R9");
    snpValid = 0; cpuReq = 0;
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0) snoop(lfsr[3], {4'd0, lfsr[7:4]}, "R6");
      else op(lfsr[3], {4'd0, lfsr[7:4]}, lfsr ^ 16'h0F0F, int'(lfsr[9:8]), "R10");
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule